// File: doc/BRIEF.md
# CRT Raster Timing Generator

This block generates the raster timing for a cathode-ray-tube style display from a bank of timing registers that use the classic CRT-controller index layout. Software writes an 8-bit index and an 8-bit data byte. The block then produces horizontal and vertical sync, a display-enable strobe, and the current pixel and line position, all clocked by the pixel clock.

Horizontal quantities are counted in characters of eight pixels. The registers hold them with fixed biases: total minus five, display end minus one, and sync start unbiased. Vertical quantities are counted in lines. They are biased by minus two (total) or minus one (display end, sync start), and their upper bits sit in separate extension registers. Both sync-end fields are short. Horizontal sync ends when the low five bits of the character counter match its field. Vertical sync ends when the low four bits of the line counter match its field plus one. After reset the registers hold a 640x480 mode: 800 pixels by 525 lines, with both syncs active low.

Sync polarity comes from a separate output-control byte. Bit 6 of that byte sets horizontal sync to active low, and bit 7 does the same for vertical sync.

Top module: `crt_raster_timer`

## Requirements
- R1: While reset is held and on the first cycle after it, pix_x and line_y are 0, disp_en is 1, and hsync and vsync sit at their inactive level (1, since both syncs reset to active low).
- R2: With reset register values, a line lasts 800 clocks, disp_en is high on line 0 for pixels 0..639, and hsync is low for exactly the 96 pixels 656..751.
- R3: The horizontal total is ({index 0x38 bit 0, index 0x00} + 5) characters of 8 pixels, and pix_x counts 0 up to 8*total-1 before it wraps to 0.
- R4: Horizontal display covers characters 0 up to the value in index 0x01, inclusive.
- R5: Horizontal sync becomes active at the character equal to index 0x04. It becomes inactive at the first later character whose low 5 bits equal index 0x05 bits 4:0.
- R6: line_y advances by one when pix_x wraps. The vertical total is ({index 0x30 bits 3:0, index 0x06} + 2) lines.
- R7: disp_en is high only while the character is within R4's range and line_y is at most {index 0x31 bits 3:0, index 0x12}.
- R8: Vertical sync becomes active at line {index 0x32 bits 3:0, index 0x10} + 1. It becomes inactive at the first later line whose low 4 bits equal (index 0x11 bits 3:0) + 1, modulo 16.
- R9: A write on the output-control strobe takes the sync polarity from wr_data: bit 6 set makes hsync active low, and bit 7 set makes vsync active low.
- R10: Register writes to indices other than 0x00, 0x01, 0x04, 0x05, 0x06, 0x10, 0x11, 0x12, 0x30, 0x31, 0x32 and 0x38 do not change the timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Timing register write strobe |
| reg_idx | input | 8 | Timing register index |
| misc_wr | input | 1 | Output-control (polarity) write strobe |
| wr_data | input | 8 | Write data shared by both strobes |
| hsync | output | 1 | Horizontal sync at the programmed polarity |
| vsync | output | 1 | Vertical sync at the programmed polarity |
| disp_en | output | 1 | High inside the active picture |
| pix_x | output | 13 | Pixel position within the line |
| line_y | output | 13 | Line position within the frame |

## Verification
The bench builds the block with its default parameters: 8-pixel characters, a 10-bit character counter and a 13-bit line counter. At those sizes a full reset-mode frame is too long to run, so the defaults are checked over one line only. Every frame-level check runs on small programmed modes. These small modes make several corners reachable: the 5-bit sync-end match well above 31 characters, a vertical sync-end nibble that wraps, and a horizontal total that needs the bit-8 extension. They also cover a vertical total, display end and sync start that need the high extension registers, all within a few thousand cycles per frame.

// File: rtl/crt_timing_pkg.sv
// Shared constants and the decoded timing configuration for the CRT raster
// timer. The register indices are kept because software decodes them.
package crt_timing_pkg;

    localparam int HC_W  = 10;  // character counter width (max total 516)
    localparam int VC_W  = 13;  // line counter width (max total 4097)
    localparam int HSE_W = 5;   // truncated horizontal sync-end field
    localparam int VSE_W = 4;   // truncated vertical sync-end field

    localparam logic [7:0] IX_HTOT   = 8'h00;
    localparam logic [7:0] IX_HDE    = 8'h01;
    localparam logic [7:0] IX_HSS    = 8'h04;
    localparam logic [7:0] IX_HSE    = 8'h05;
    localparam logic [7:0] IX_VTOT   = 8'h06;
    localparam logic [7:0] IX_VSS    = 8'h10;
    localparam logic [7:0] IX_VSE    = 8'h11;
    localparam logic [7:0] IX_VDE    = 8'h12;
    localparam logic [7:0] IX_VTOT_X = 8'h30;
    localparam logic [7:0] IX_VDE_X  = 8'h31;
    localparam logic [7:0] IX_VSS_X  = 8'h32;
    localparam logic [7:0] IX_HTOT_X = 8'h38;

    // Raw (still biased) register contents.
    typedef struct packed {
        logic [8:0]       htot_m5;
        logic [7:0]       hde_m1;
        logic [7:0]       hss;
        logic [HSE_W-1:0] hse;
        logic [11:0]      vtot_m2;
        logic [11:0]      vss_m1;
        logic [VSE_W-1:0] vse_m1;
        logic [11:0]      vde_m1;
        logic             hneg;
        logic             vneg;
    } crt_cfg_t;

    // 640x480: 100 chars/line, 525 lines, both syncs active low.
    localparam crt_cfg_t CFG_RESET = '{
        htot_m5: 9'd95,  hde_m1: 8'd79,  hss: 8'd82,     hse: 5'd30,
        vtot_m2: 12'd523, vss_m1: 12'd489, vse_m1: 4'd11, vde_m1: 12'd479,
        hneg: 1'b1, vneg: 1'b1
    };

endpackage

// File: rtl/crt_reg_bank.sv
// Timing register bank. Captures index/data writes into the biased fields
// and polarity writes into two flags. Assumes one write per cycle; an index
// that is not decoded leaves every field unchanged.
module crt_reg_bank
    import crt_timing_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic [7:0] reg_idx,
    input  logic       misc_wr,
    input  logic [7:0] wr_data,
    output crt_cfg_t   cfg
);

    logic idx_known;

    // Flag whether the write index selects a stored field.
    always_comb begin
        unique case (reg_idx)
            IX_HTOT, IX_HDE, IX_HSS, IX_HSE, IX_VTOT, IX_VSS, IX_VSE,
            IX_VDE, IX_VTOT_X, IX_VDE_X, IX_VSS_X, IX_HTOT_X: idx_known = 1'b1;
            default: idx_known = 1'b0;
        endcase
    end

    // Capture register and polarity writes; restore the default mode on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= CFG_RESET;
        end else begin
            if (reg_wr) begin
                case (reg_idx)
                    IX_HTOT:   cfg.htot_m5[7:0]  <= wr_data;
                    IX_HTOT_X: cfg.htot_m5[8]    <= wr_data[0];
                    IX_HDE:    cfg.hde_m1        <= wr_data;
                    IX_HSS:    cfg.hss           <= wr_data;
                    IX_HSE:    cfg.hse           <= wr_data[HSE_W-1:0];
                    IX_VTOT:   cfg.vtot_m2[7:0]  <= wr_data;
                    IX_VTOT_X: cfg.vtot_m2[11:8] <= wr_data[3:0];
                    IX_VSS:    cfg.vss_m1[7:0]   <= wr_data;
                    IX_VSS_X:  cfg.vss_m1[11:8]  <= wr_data[3:0];
                    IX_VSE:    cfg.vse_m1        <= wr_data[VSE_W-1:0];
                    IX_VDE:    cfg.vde_m1[7:0]   <= wr_data;
                    IX_VDE_X:  cfg.vde_m1[11:8]  <= wr_data[3:0];
                    default:   ;
                endcase
            end
            if (misc_wr) begin
                cfg.hneg <= wr_data[6];
                cfg.vneg <= wr_data[7];
            end
        end
    end

    // R10
    ignore_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !idx_known && !misc_wr) |=> $stable(cfg));

    // R9
    misc_pol_chk: assert property (@(posedge clk) disable iff (!rst_n)
        misc_wr |=> (cfg.hneg == $past(wr_data[6]) && cfg.vneg == $past(wr_data[7])));

endmodule

// File: rtl/crt_horiz_gen.sv
// Horizontal generator: dot-in-character counter, character counter and the
// horizontal sync state. Undoes the -5 and -1 biases. Sync ends on a match of
// the truncated low bits only. Assumes the register fields may change at any
// time; a counter beyond a newly shortened total wraps at the next character.
module crt_horiz_gen
    import crt_timing_pkg::*;
#(
    parameter int DOT_BITS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [8:0]       htot_m5,
    input  logic [7:0]       hde_m1,
    input  logic [7:0]       hss,
    input  logic [HSE_W-1:0] hse,
    output logic [DOT_BITS-1:0] dot,
    output logic [HC_W-1:0]  hc,
    output logic             hs_on,
    output logic             h_disp,
    output logic             line_end
);

    logic [HC_W-1:0] htot_last;
    logic [HC_W-1:0] hc_nxt;
    logic            dot_last;

    // Last character index of the line and the next character value.
    always_comb begin
        htot_last = HC_W'(htot_m5) + HC_W'(4);
        dot_last  = &dot;
        hc_nxt    = (hc >= htot_last) ? '0 : hc + 1'b1;
        line_end  = dot_last && (hc >= htot_last);
        h_disp    = (hc <= HC_W'(hde_m1));
    end

    // Advance dot and character counters; set and clear the sync state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dot   <= '0;
            hc    <= '0;
            hs_on <= 1'b0;
        end else begin
            dot <= dot + 1'b1;
            if (dot_last) begin
                hc <= hc_nxt;
                if (hc_nxt == HC_W'(hss))
                    hs_on <= 1'b1;
                else if (hc_nxt[HSE_W-1:0] == hse)
                    hs_on <= 1'b0;
            end
        end
    end

    // R5
    hs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_on) |-> (hc == HC_W'($past(hss)) && dot == '0));

    // R5
    hs_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hs_on) |-> (hc[HSE_W-1:0] == $past(hse) && dot == '0));

    // R3
    hwrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_end |=> (hc == '0 && dot == '0));

endmodule

// File: rtl/crt_vert_gen.sv
// Vertical generator: line counter and vertical sync state. Advances once per
// horizontal total. Undoes the -2 and -1 biases. Sync ends when the low
// nibble of the line equals the stored field plus one.
module crt_vert_gen
    import crt_timing_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_end,
    input  logic [11:0]      vtot_m2,
    input  logic [11:0]      vss_m1,
    input  logic [VSE_W-1:0] vse_m1,
    input  logic [11:0]      vde_m1,
    output logic [VC_W-1:0]  vc,
    output logic             vs_on,
    output logic             v_disp
);

    logic [VC_W-1:0]  vtot_last;
    logic [VC_W-1:0]  vs_first;
    logic [VSE_W-1:0] vs_stop;
    logic [VC_W-1:0]  vc_nxt;

    // Remove the biases and compute the next line value.
    always_comb begin
        vtot_last = VC_W'(vtot_m2) + VC_W'(1);
        vs_first  = VC_W'(vss_m1) + VC_W'(1);
        vs_stop   = vse_m1 + 1'b1;
        vc_nxt    = (vc >= vtot_last) ? '0 : vc + 1'b1;
        v_disp    = (vc <= VC_W'(vde_m1));
    end

    // Step the line counter at line end; set and clear the sync state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vc    <= '0;
            vs_on <= 1'b0;
        end else if (line_end) begin
            vc <= vc_nxt;
            if (vc_nxt == vs_first)
                vs_on <= 1'b1;
            else if (vc_nxt[VSE_W-1:0] == vs_stop)
                vs_on <= 1'b0;
        end
    end

    // R6
    vstep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(vc) |-> $past(line_end));

    // R8
    vs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vs_on) |-> (vc == VC_W'($past(vss_m1)) + VC_W'(1)));

endmodule

// File: rtl/crt_raster_timer.sv
// Top of the CRT raster timer. Joins the register bank with the horizontal
// and vertical generators and applies the sync polarity. Assumes a
// free-running pixel clock; the outputs follow the counters directly.
module crt_raster_timer
    import crt_timing_pkg::*;
#(
    parameter int DOT_BITS = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      reg_wr,
    input  logic [7:0]                reg_idx,
    input  logic                      misc_wr,
    input  logic [7:0]                wr_data,
    output logic                      hsync,
    output logic                      vsync,
    output logic                      disp_en,
    output logic [HC_W+DOT_BITS-1:0]  pix_x,
    output logic [VC_W-1:0]           line_y
);

    crt_cfg_t            cfg;
    logic [DOT_BITS-1:0] dot;
    logic [HC_W-1:0]     hc;
    logic                hs_on, vs_on, h_disp, v_disp, line_end;
    logic [VC_W-1:0]     vc;

    crt_reg_bank u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
        .misc_wr(misc_wr), .wr_data(wr_data), .cfg(cfg)
    );

    crt_horiz_gen #(.DOT_BITS(DOT_BITS)) u_horiz (
        .clk(clk), .rst_n(rst_n), .htot_m5(cfg.htot_m5), .hde_m1(cfg.hde_m1),
        .hss(cfg.hss), .hse(cfg.hse), .dot(dot), .hc(hc), .hs_on(hs_on),
        .h_disp(h_disp), .line_end(line_end)
    );

    crt_vert_gen u_vert (
        .clk(clk), .rst_n(rst_n), .line_end(line_end), .vtot_m2(cfg.vtot_m2),
        .vss_m1(cfg.vss_m1), .vse_m1(cfg.vse_m1), .vde_m1(cfg.vde_m1),
        .vc(vc), .vs_on(vs_on), .v_disp(v_disp)
    );

    // Drive the outputs: polarity-adjusted syncs, combined enable, positions.
    always_comb begin
        hsync   = hs_on ^ cfg.hneg;
        vsync   = vs_on ^ cfg.vneg;
        disp_en = h_disp & v_disp;
        pix_x   = {hc, dot};
        line_y  = vc;
    end

    // R7
    de_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_en |-> (line_y <= VC_W'(cfg.vde_m1)));

endmodule

// File: tb/crt_raster_timer_tb.sv
module crt_raster_timer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DOT = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_idx = 8'h00;
    logic        misc_wr = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic        hsync, vsync, disp_en;
    logic [12:0] pix_x;
    logic [12:0] line_y;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    crt_raster_timer dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
        .misc_wr(misc_wr), .wr_data(wr_data), .hsync(hsync), .vsync(vsync),
        .disp_en(disp_en), .pix_x(pix_x), .line_y(line_y)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] idx, input logic [7:0] data);
        @(negedge clk);
        reg_wr = 1'b1; reg_idx = idx; wr_data = data;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic wr_misc(input logic [7:0] data);
        @(negedge clk);
        misc_wr = 1'b1; wr_data = data;
        @(negedge clk);
        misc_wr = 1'b0;
    endtask

    task automatic seek_frame_start();
        @(negedge clk);
        while (!(pix_x == 13'd0 && line_y == 13'd0)) @(negedge clk);
    endtask

    // Run one whole frame and compare every cycle against a timing model
    // built from the programmed character and line boundaries.
    task automatic check_frame(input string tag, input int hchars, input int hde_c,
                               input int hs_a, input int hs_b, input int vlines,
                               input int vde_l, input int vs_a, input int vs_b,
                               input bit hneg, input bit vneg);
        int bad_x = 0, bad_y = 0, bad_de = 0, bad_hs = 0, bad_vs = 0;
        int line_clk = hchars * DOT;
        seek_frame_start();
        seek_frame_start();
        for (int t = 0; t < line_clk * vlines; t++) begin
            int px = t % line_clk;
            int ln = t / line_clk;
            int ch = px / DOT;
            bit e_de = (ch < hde_c) && (ln < vde_l);
            bit e_hs = ((ch >= hs_a) && (ch < hs_b)) ^ hneg;
            bit e_vs = ((ln >= vs_a) && (ln < vs_b)) ^ vneg;
            if (int'(pix_x) != px) begin
                if (bad_x == 0) $display("  %s pix_x mismatch t=%0d got %0d want %0d", tag, t, pix_x, px);
                bad_x++;
            end
            if (int'(line_y) != ln) begin
                if (bad_y == 0) $display("  %s line_y mismatch t=%0d got %0d want %0d", tag, t, line_y, ln);
                bad_y++;
            end
            if (disp_en != e_de) bad_de++;
            if (hsync != e_hs) begin
                if (bad_hs == 0) $display("  %s hsync mismatch t=%0d got %0d want %0d", tag, t, hsync, e_hs);
                bad_hs++;
            end
            if (vsync != e_vs) bad_vs++;
            @(negedge clk);
        end
        chk({tag, " R3 pix_x mismatches"}, bad_x, 0);
        chk({tag, " R6 line_y mismatches"}, bad_y, 0);
        chk({tag, " R4 R7 disp_en mismatches"}, bad_de, 0);
        chk({tag, " R5 hsync mismatches"}, bad_hs, 0);
        chk({tag, " R8 vsync mismatches"}, bad_vs, 0);
        chk({tag, " R6 wrap to line 0"}, int'(line_y), 0);
    endtask

    // Small mode: 10 chars, 6 shown, hsync 7..8; 8 lines, 5 shown, vsync line 6.
    task automatic prog_small();
        wr_reg(8'h00, 8'd5);  wr_reg(8'h38, 8'd0);
        wr_reg(8'h01, 8'd5);  wr_reg(8'h04, 8'd7);  wr_reg(8'h05, 8'd9);
        wr_reg(8'h06, 8'd6);  wr_reg(8'h30, 8'd0);
        wr_reg(8'h12, 8'd4);  wr_reg(8'h31, 8'd0);
        wr_reg(8'h10, 8'd5);  wr_reg(8'h32, 8'd0);  wr_reg(8'h11, 8'd6);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1 pix_x in reset", int'(pix_x), 0);
        chk("R1 line_y in reset", int'(line_y), 0);
        chk("R1 disp_en in reset", int'(disp_en), 1);
        chk("R1 hsync idle", int'(hsync), 1);
        chk("R1 vsync idle", int'(vsync), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 pix_x after release", int'(pix_x), 1);
        chk("R1 hsync after release", int'(hsync), 1);
    endtask

    task automatic t_default_line();
        int n_de = 0, n_hs = 0, first_hs = -1;
        // first sample after release was pix 1; account for pixel 0 as shown
        n_de = 1;
        for (int i = 1; i < 800; i++) begin
            if (disp_en) n_de++;
            if (!hsync) begin
                n_hs++;
                if (first_hs < 0) first_hs = int'(pix_x);
            end
            @(negedge clk);
        end
        chk("R2 displayed pixels on line 0", n_de, 640);
        chk("R2 hsync low pixels", n_hs, 96);
        chk("R2 hsync first low pixel", first_hs, 656);
        chk("R2 line_y after 800 clocks", int'(line_y), 1);
        chk("R2 pix_x after 800 clocks", int'(pix_x), 0);
    endtask

    task automatic t_small();
        prog_small();
        check_frame("small", 10, 6, 7, 9, 8, 5, 6, 7, 1'b1, 1'b1);
    endtask

    task automatic t_truncated();
        // 50 chars, 40 shown, sync 42..46 (end field 15 matches char 47);
        // 24 lines, 10 shown, vsync line 20 (end nibble 4+1 matches line 21).
        wr_reg(8'h00, 8'd45); wr_reg(8'h01, 8'd39);
        wr_reg(8'h04, 8'd42); wr_reg(8'h05, 8'd47);
        wr_reg(8'h06, 8'd22); wr_reg(8'h12, 8'd9);
        wr_reg(8'h10, 8'd19); wr_reg(8'h11, 8'd4);
        check_frame("truncated R5 R8", 50, 40, 42, 47, 24, 10, 20, 21, 1'b1, 1'b1);
    endtask

    task automatic t_polarity();
        prog_small();
        wr_misc(8'h00);
        check_frame("R9 both positive", 10, 6, 7, 9, 8, 5, 6, 7, 1'b0, 1'b0);
        wr_misc(8'h40);
        check_frame("R9 hsync negative only", 10, 6, 7, 9, 8, 5, 6, 7, 1'b1, 1'b0);
        wr_misc(8'hC0);
    endtask

    task automatic t_high_bits();
        // Horizontal bit 8: 261 chars; 2 lines, all shown, no vsync.
        prog_small();
        wr_reg(8'h00, 8'd0); wr_reg(8'h38, 8'd1);
        wr_reg(8'h06, 8'd0);
        check_frame("R3 hbit8", 261, 6, 7, 9, 2, 5, 6, 7, 1'b1, 1'b1);
        // Vertical extensions: 5 chars; 258 lines, 257 shown, vsync line 256.
        wr_reg(8'h38, 8'd0);
        wr_reg(8'h06, 8'd0);   wr_reg(8'h30, 8'd1);
        wr_reg(8'h12, 8'd0);   wr_reg(8'h31, 8'd1);
        wr_reg(8'h10, 8'hFF);  wr_reg(8'h32, 8'd0);  wr_reg(8'h11, 8'd0);
        check_frame("R6 R7 R8 vext", 5, 6, 7, 9, 258, 257, 256, 257, 1'b1, 1'b1);
    endtask

    task automatic t_ignored();
        prog_small();
        wr_reg(8'h02, 8'hFF); wr_reg(8'h07, 8'hFF);
        wr_reg(8'h13, 8'hFF); wr_reg(8'h3C, 8'hFF);
        check_frame("R10 after unused writes", 10, 6, 7, 9, 8, 5, 6, 7, 1'b1, 1'b1);
    endtask

    initial begin
        t_reset();
        t_default_line();
        t_small();
        t_truncated();
        t_polarity();
        t_high_bits();
        t_ignored();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule